// File: doc/BRIEF.md
# Outbound Bridge Control Register with Error-Halt Sequencer

This block is a single 32-bit control and status word for the outbound side of a bus bridge, together with the small amount of timed logic its bits drive. Software writes it to turn outbound acceptance on and off, to pick how delayed reads are matched, to enable three interrupt sources and to fire a one-clock system-error pulse by hand. Software reads it to see whether a discard timer has expired. That status bit clears itself when it is read.

When halt-on-error is armed and the queue reports an error on an outbound write, a three-step sequencer runs. It first clears the outbound enable, then issues a one-cycle flush command for the queued writes, then raises a level interrupt. Reads already in flight finish outside this block. Bus decode, the queue and the timers are outside the block and appear only as strobes.

Top module: `obctl_reg`

## Requirements
- R1: After reset every implemented bit reads 0 and every output (enable, alias, capability, pulses, interrupts) is 0.
- R2: The register answers only at address 0x070. Bits 31:20, 18:17, 14:10, 7:4, 2 and 0 always read 0 and ignore writes. A write to any other address changes nothing. `bus_rdata` shows the register during a matching read cycle and 0 otherwise.
- R3: Bit 1 is read/write and drives `ob_enable`. While it is 0, outbound requests are refused.
- R4: Bit 19 is read/write and drives `rd_alias`: 1 means the read command type is ignored when matching delayed reads. Bit 3 is read/write and also drives `bist_capable`.
- R5: A write that sets bit 16 while it holds 0 makes `sys_err_pulse` high for exactly the following cycle. Writes of 1 while bit 16 is already 1 make no pulse. Once bit 16 has been written back to 0, a new 0-to-1 write pulses again.
- R6: Bit 15 is set by a pulse on any of the `tmr_expire` inputs and is cleared by a matching read. When an expiry and a read occur in the same cycle, the bit stays 1.
- R7: With bit 9 set, a `serr_detect` pulse sets `irq_serr` from the next cycle on. With bit 9 clear, detection has no effect.
- R8: With bit 3 set, a `bist_start` pulse sets `irq_bist` from the next cycle on. With bit 3 clear, it has no effect.
- R9: With bit 8 set, `ob_wr_err` sampled at edge E starts the halt. Bit 1 reads 0 from the second edge after E. `flush_pulse` is high for the single cycle between the second and third edges. `irq_halt` is high from the fourth edge.
- R10: If software writes bit 1 to 1 in the cycle in which the halt clears it, the hardware clear wins.
- R11: A further `ob_wr_err` while a halt sequence is running is ignored, and so is any `ob_wr_err` while bit 8 is 0.
- R12: Each interrupt holds until its `irq_ack` bit is pulsed (bit 0 serr, bit 1 self-test, bit 2 halt). If a cause and its acknowledge arrive in the same cycle, the interrupt stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| tmr_expire | input | NUM_TIMERS | Discard-timer expiry pulses |
| serr_detect | input | 1 | External system error seen |
| bist_start | input | 1 | Self-test start request |
| ob_wr_err | input | 1 | Error reported on an outbound write |
| irq_ack | input | 3 | Interrupt acknowledge pulses |
| ob_enable | output | 1 | Outbound acceptance enable |
| rd_alias | output | 1 | Read-command alias mode |
| bist_capable | output | 1 | Self-test interrupt capability |
| sys_err_pulse | output | 1 | Manual system-error pulse |
| flush_pulse | output | 1 | Flush command for queued writes |
| irq_serr | output | 1 | System-error-detected interrupt |
| irq_bist | output | 1 | Self-test interrupt |
| irq_halt | output | 1 | Halt-on-error interrupt |

## Verification
The bench builds the block with its defaults: a 12-bit address, four expiry inputs and combinational read data. With these settings it can pulse every timer index one at a time, miss the register with the neighbouring word address, and observe the read-clear race in the same cycle in which the read data is shown. The halt is driven with an overlapping software write and a second error, so the clear priority and the lockout are both reached.

// File: rtl/obctl_pkg.sv
package obctl_pkg;
   localparam int REG_W      = 32;
   localparam int B_OB_EN    = 1;
   localparam int B_BIST_IE  = 3;
   localparam int B_HALT_EN  = 8;
   localparam int B_SERR_IE  = 9;
   localparam int B_DT_STAT  = 15;
   localparam int B_SERR_MAN = 16;
   localparam int B_ALIAS    = 19;

   localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << B_OB_EN)   | (REG_W'(1) << B_BIST_IE)  |
      (REG_W'(1) << B_HALT_EN) | (REG_W'(1) << B_SERR_IE)  |
      (REG_W'(1) << B_DT_STAT) | (REG_W'(1) << B_SERR_MAN) |
      (REG_W'(1) << B_ALIAS);

   localparam int NUM_IRQ  = 3;
   localparam int IRQ_SERR = 0;
   localparam int IRQ_BIST = 1;
   localparam int IRQ_HALT = 2;

   typedef enum logic [1:0] {
      HS_IDLE  = 2'd0,
      HS_CLEAR = 2'd1,
      HS_FLUSH = 2'd2,
      HS_RAISE = 2'd3
   } halt_state_e;
endpackage

// File: rtl/obctl_flag.sv
module obctl_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/obctl_oneshot.sv
module obctl_oneshot (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   output logic held,
   output logic pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held  <= 1'b0;
         pulse <= 1'b0;
      end else begin
         pulse <= wr_en & wr_bit & ~held;
         if (wr_en) held <= wr_bit;
      end
   end
endmodule

// File: rtl/obctl_halt_seq.sv
module obctl_halt_seq
   import obctl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic halt_en,
   input  logic err_in,
   output logic hw_clr,
   output logic flush,
   output logic raise
);
   halt_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         HS_IDLE:  if (halt_en && err_in) st_d = HS_CLEAR;
         HS_CLEAR: st_d = HS_FLUSH;
         HS_FLUSH: st_d = HS_RAISE;
         HS_RAISE: st_d = HS_IDLE;
         default:  st_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= HS_IDLE;
      else        st_q <= st_d;
   end

   assign hw_clr = (st_q == HS_CLEAR);
   assign flush  = (st_q == HS_FLUSH);
   assign raise  = (st_q == HS_RAISE);
endmodule

// File: rtl/obctl_reg.sv
module obctl_reg
   import obctl_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int unsigned REG_OFFSET = 'h070,
   parameter int          NUM_TIMERS = 4,
   parameter int          RD_PIPE    = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [REG_W-1:0]      bus_wdata,
   output logic [REG_W-1:0]      bus_rdata,
   input  logic [NUM_TIMERS-1:0] tmr_expire,
   input  logic                  serr_detect,
   input  logic                  bist_start,
   input  logic                  ob_wr_err,
   input  logic [NUM_IRQ-1:0]    irq_ack,
   output logic                  ob_enable,
   output logic                  rd_alias,
   output logic                  bist_capable,
   output logic                  sys_err_pulse,
   output logic                  flush_pulse,
   output logic                  irq_serr,
   output logic                  irq_bist,
   output logic                  irq_halt
);
   localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFFSET);

   // elaboration-time parameter checks
   if (NUM_TIMERS < 1 || NUM_TIMERS > 32) begin : g_bad_timers
      $error("obctl_reg: NUM_TIMERS must be 1..32");
   end
   if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_addr
      $error("obctl_reg: ADDR_W must be 3..32");
   end
   if ((REG_OFFSET % 4) != 0) begin : g_bad_align
      $error("obctl_reg: REG_OFFSET must be word aligned");
   end
   if (ADDR_W < 32 && (REG_OFFSET >> ADDR_W) != 0) begin : g_bad_off
      $error("obctl_reg: REG_OFFSET does not fit ADDR_W");
   end
   if (RD_PIPE != 0 && RD_PIPE != 1) begin : g_bad_pipe
      $error("obctl_reg: RD_PIPE must be 0 or 1");
   end

   logic wr_hit, rd_hit;
   assign wr_hit = bus_wr && (bus_addr == OFF);
   assign rd_hit = bus_rd && (bus_addr == OFF);

   // plain read/write bits
   logic ob_en_q, bist_ie_q, halt_en_q, serr_ie_q, alias_q;
   logic hw_clr, seq_raise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ob_en_q   <= 1'b0;
         bist_ie_q <= 1'b0;
         halt_en_q <= 1'b0;
         serr_ie_q <= 1'b0;
         alias_q   <= 1'b0;
      end else begin
         if (hw_clr)      ob_en_q <= 1'b0;
         else if (wr_hit) ob_en_q <= bus_wdata[B_OB_EN];
         if (wr_hit) begin
            bist_ie_q <= bus_wdata[B_BIST_IE];
            halt_en_q <= bus_wdata[B_HALT_EN];
            serr_ie_q <= bus_wdata[B_SERR_IE];
            alias_q   <= bus_wdata[B_ALIAS];
         end
      end
   end

   // manual system-error one-shot
   logic man_held;
   obctl_oneshot u_man (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_hit),
      .wr_bit (bus_wdata[B_SERR_MAN]),
      .held   (man_held),
      .pulse  (sys_err_pulse)
   );

   // discard-timer status, read-clear with set priority
   logic dt_stat;
   obctl_flag u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (|tmr_expire),
      .clr   (rd_hit),
      .q     (dt_stat)
   );

   // halt-on-error sequencer
   obctl_halt_seq u_halt (
      .clk     (clk),
      .rst_n   (rst_n),
      .halt_en (halt_en_q),
      .err_in  (ob_wr_err),
      .hw_clr  (hw_clr),
      .flush   (flush_pulse),
      .raise   (seq_raise)
   );

   // interrupt bank
   logic [NUM_IRQ-1:0] irq_set, irq_q;
   always_comb begin
      irq_set           = '0;
      irq_set[IRQ_SERR] = serr_detect & serr_ie_q;
      irq_set[IRQ_BIST] = bist_start & bist_ie_q;
      irq_set[IRQ_HALT] = seq_raise;
   end

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
      obctl_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (irq_set[g]),
         .clr   (irq_ack[g]),
         .q     (irq_q[g])
      );
   end

   assign irq_serr = irq_q[IRQ_SERR];
   assign irq_bist = irq_q[IRQ_BIST];
   assign irq_halt = irq_q[IRQ_HALT];

   // register image and read path
   logic [REG_W-1:0] img;
   always_comb begin
      img             = '0;
      img[B_OB_EN]    = ob_en_q;
      img[B_BIST_IE]  = bist_ie_q;
      img[B_HALT_EN]  = halt_en_q;
      img[B_SERR_IE]  = serr_ie_q;
      img[B_DT_STAT]  = dt_stat;
      img[B_SERR_MAN] = man_held;
      img[B_ALIAS]    = alias_q;
   end

   if (RD_PIPE == 0) begin : g_rd_comb
      assign bus_rdata = rd_hit ? (img & IMPL_MASK) : '0;
   end else begin : g_rd_reg
      logic [REG_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rdata_q <= '0;
         else if (rd_hit) rdata_q <= img & IMPL_MASK;
         else             rdata_q <= '0;
      end
      assign bus_rdata = rdata_q;
   end

   assign ob_enable    = ob_en_q;
   assign rd_alias     = alias_q;
   assign bist_capable = bist_ie_q;
endmodule

// File: rtl/obctl_reg_chk.sv
module obctl_reg_chk
   import obctl_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] bus_rdata,
   input logic             serr_detect,
   input logic             ob_enable,
   input logic             sys_err_pulse,
   input logic             flush_pulse,
   input logic             irq_serr,
   input logic             irq_halt
);
   // R2: reserved positions never show a one
   assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~IMPL_MASK) == '0);

   // R5: the manual pulse never lasts two cycles
   assert_serr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sys_err_pulse |=> !sys_err_pulse);

   // R9 / R10: flush only goes out once acceptance is already off
   assert_flush_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |-> !ob_enable);

   // R9: flush is a single cycle
   assert_flush_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |=> !flush_pulse);

   // R9: halt interrupt comes two cycles after the flush
   assert_halt_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_halt) |-> $past(flush_pulse, 2));

   // R7: serr interrupt only rises after a detection
   assert_serr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_serr) |-> $past(serr_detect));
endmodule

bind obctl_reg obctl_reg_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_rdata     (bus_rdata),
   .serr_detect   (serr_detect),
   .ob_enable     (ob_enable),
   .sys_err_pulse (sys_err_pulse),
   .flush_pulse   (flush_pulse),
   .irq_serr      (irq_serr),
   .irq_halt      (irq_halt)
);

// File: tb/sim_obctl_reg.sv
`timescale 1ns/100ps
module sim_obctl_reg;
   localparam int AW  = 12;
   localparam int NT  = 4;
   localparam logic [AW-1:0] OFF  = 12'h070;
   localparam logic [AW-1:0] MISS = 12'h074;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NT-1:0] tmr_expire = '0;
   logic          serr_detect = 1'b0, bist_start = 1'b0, ob_wr_err = 1'b0;
   logic [2:0]    irq_ack = '0;
   logic          ob_enable, rd_alias, bist_capable, sys_err_pulse;
   logic          flush_pulse, irq_serr, irq_bist, irq_halt;

   always #2 clk = ~clk;

   obctl_reg #(.ADDR_W(AW), .REG_OFFSET('h070), .NUM_TIMERS(NT), .RD_PIPE(0)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tmr_expire(tmr_expire), .serr_detect(serr_detect), .bist_start(bist_start),
      .ob_wr_err(ob_wr_err), .irq_ack(irq_ack), .ob_enable(ob_enable),
      .rd_alias(rd_alias), .bist_capable(bist_capable), .sys_err_pulse(sys_err_pulse),
      .flush_pulse(flush_pulse), .irq_serr(irq_serr), .irq_bist(irq_bist),
      .irq_halt(irq_halt)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // behavioural reference state
   bit m_en, m_bie, m_hen, m_sie, m_stat, m_man, m_al, m_pulse;
   bit m_iserr, m_ibist, m_ihalt;
   int m_step = 0;   // 0 idle, 1 clearing, 2 flushing, 3 raising

   function automatic logic [31:0] model_img();
      logic [31:0] v = '0;
      v[1] = m_en;  v[3] = m_bie; v[8] = m_hen; v[9] = m_sie;
      v[15] = m_stat; v[16] = m_man; v[19] = m_al;
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_bie = 0; m_hen = 0; m_sie = 0; m_stat = 0; m_man = 0;
         m_al = 0; m_pulse = 0; m_iserr = 0; m_ibist = 0; m_ihalt = 0; m_step = 0;
      end else begin
         bit wh, rh, n_en, n_pulse, n_man, n_stat, n_is, n_ib, n_ih;
         int n_step;
         wh = bus_wr && bus_addr == OFF;
         rh = bus_rd && bus_addr == OFF;
         n_pulse = wh && bus_wdata[16] && !m_man;
         n_man   = wh ? bus_wdata[16] : m_man;
         n_en    = (m_step == 1) ? 1'b0 : (wh ? bus_wdata[1] : m_en);
         n_stat  = (|tmr_expire) ? 1'b1 : (rh ? 1'b0 : m_stat);
         n_is    = (serr_detect && m_sie) ? 1'b1 : (irq_ack[0] ? 1'b0 : m_iserr);
         n_ib    = (bist_start && m_bie) ? 1'b1 : (irq_ack[1] ? 1'b0 : m_ibist);
         n_ih    = (m_step == 3) ? 1'b1 : (irq_ack[2] ? 1'b0 : m_ihalt);
         if (m_step == 0) n_step = (ob_wr_err && m_hen) ? 1 : 0;
         else             n_step = (m_step == 3) ? 0 : m_step + 1;
         if (wh) begin
            m_bie = bus_wdata[3]; m_hen = bus_wdata[8];
            m_sie = bus_wdata[9]; m_al = bus_wdata[19];
         end
         m_pulse = n_pulse; m_man = n_man; m_en = n_en; m_stat = n_stat;
         m_iserr = n_is; m_ibist = n_ib; m_ihalt = n_ih; m_step = n_step;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every cycle shortly before the rising edge
   always @(negedge clk) begin
      #1.5;
      if (!done) begin
         logic [31:0] exp_rd;
         exp_rd = (bus_rd && bus_addr == OFF) ? model_img() : 32'h0;
         chk("R1 R2 R6 bus_rdata", bus_rdata, exp_rd);
         chk("R3 R9 R10 R11 ob_enable", 32'(ob_enable), 32'(m_en));
         chk("R4 rd_alias", 32'(rd_alias), 32'(m_al));
         chk("R4 bist_capable", 32'(bist_capable), 32'(m_bie));
         chk("R5 sys_err_pulse", 32'(sys_err_pulse), 32'(m_pulse));
         chk("R9 R11 flush_pulse", 32'(flush_pulse), 32'(m_step == 2));
         chk("R7 R12 irq_serr", 32'(irq_serr), 32'(m_iserr));
         chk("R8 R12 irq_bist", 32'(irq_bist), 32'(m_ibist));
         chk("R9 R11 R12 irq_halt", 32'(irq_halt), 32'(m_ihalt));
      end
   end

   // stimulus helpers: inputs change 1 ns after the falling edge
   task automatic nxt();
      @(negedge clk); #1;
      bus_wr = 0; bus_rd = 0; bus_addr = OFF; bus_wdata = '0;
      tmr_expire = '0; serr_detect = 0; bist_start = 0; ob_wr_err = 0; irq_ack = '0;
   endtask
   task automatic wr(input logic [31:0] d, input logic [AW-1:0] a = OFF);
      nxt(); bus_wr = 1; bus_addr = a; bus_wdata = d;
   endtask
   task automatic rd(input logic [AW-1:0] a = OFF);
      nxt(); bus_rd = 1; bus_addr = a;
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) nxt();
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      rd();                         // R1: reset image
      idle(1);
      // R2 R3 R4: write everything, reserved ignored
      wr(32'hFFFF_FFFF); rd(); idle(1);
      wr(32'h0, MISS); rd(); rd(MISS); idle(1);    // R2 other address
      wr(32'h0000_0000); rd();
      wr(32'h0008_000A); rd(); idle(1);            // alias, bist, enable
      // R5: one-shot and lockout
      wr(32'h0001_0000); idle(2);
      wr(32'h0001_0000); idle(2);
      wr(32'h0001_0002); rd(); idle(1);
      wr(32'h0000_0000); wr(32'h0001_0000); idle(2);
      wr(32'h0000_0000);
      // R6: each timer, read-clear, simultaneous set and read
      for (int t = 0; t < NT; t++) begin
         nxt(); tmr_expire[t] = 1; rd(); rd(); idle(1);
      end
      nxt(); tmr_expire = 4'b1010;
      rd(); tmr_expire = 4'b0001;
      rd(); rd(); idle(1);
      // R7: serr detect disabled, then enabled, acks
      nxt(); serr_detect = 1; idle(1);
      wr(32'h0000_0200);
      nxt(); serr_detect = 1; idle(2);
      nxt(); irq_ack = 3'b001; idle(1);
      nxt(); serr_detect = 1; nxt(); serr_detect = 1; irq_ack = 3'b001; idle(2);  // R12
      nxt(); irq_ack = 3'b001; idle(1);
      // R8: self-test request
      wr(32'h0); nxt(); bist_start = 1; idle(1);
      wr(32'h0000_0008);
      nxt(); bist_start = 1; idle(2);
      nxt(); irq_ack = 3'b010; idle(1);
      // R11: error with halt disabled
      wr(32'h0000_0002); nxt(); ob_wr_err = 1; idle(3);
      // R9 R10 R11: halt with overlapping write and second error
      wr(32'h0000_0102);
      nxt(); ob_wr_err = 1;
      wr(32'h0000_0102);              // lands in the clearing cycle
      nxt(); ob_wr_err = 1;           // during halt, ignored
      idle(4); rd(); idle(1);
      nxt(); irq_ack = 3'b100; idle(2);
      // re-enable, second full halt, ack in raise cycle
      wr(32'h0000_0102); idle(1);
      nxt(); ob_wr_err = 1; idle(2);
      nxt(); irq_ack = 3'b100; idle(3);
      nxt(); irq_ack = 3'b111; idle(2);
      rd(); idle(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule